// File: doc/BRIEF.md
# UART Fractional Bit-Timing Generator

This block produces the bit timing for a ten-bit asynchronous serial frame: one start bit, eight data bits and one stop bit. An integer prescaler divides the system clock into base ticks. A packed oversampling word sets how many base ticks each bit of the frame lasts. The word has four fields, and each field covers a fixed group of bit positions. Giving neighbouring groups different lengths sets the average baud rate more finely than a fixed sixteen-times oversampling scheme can. When all four fields are zero, the block falls back to that fixed scheme.

A frame begins with a one-cycle start pulse. From then on the block reports three things: the end of each bit with a boundary strobe, the sampling point inside each bit with a mid-bit strobe, and the position of the bit now being timed with an index output. It marks the end of the frame with a done pulse. A serialiser or deserialiser attached to these outputs shifts data on the boundary strobe or samples the line on the mid-bit strobe.

Top module: `uart_bit_timer`

## Requirements
- R1: After reset, bitStrobe, midStrobe and frameDone are low, bitIdx is 0, and no strobe appears until a frame is started.
- R2: The divisor input sets the base-tick period in clocks. A value D from 1 to 1023 gives one base tick every D clocks. A value of 0 is handled as 1.
- R3: When all four oversampling fields are zero, every bit of the frame lasts 16 base ticks.
- R4: Field k of osampWord (k = 0..3) sits in bits [8k+5:8k]. Bits 6 and 7 of each byte are ignored. If any field is non-zero, frame bits 1 to 3 last field0 ticks each, bits 4 to 6 last field1, bits 7 and 8 last field2, and bits 9 and 10 last field3. A whole frame then lasts D × (3·(f0+f1) + 2·(f2+f3)) clocks.
- R5: When at least one field is non-zero, any field that is zero is handled as 1.
- R6: For a bit that lasts L ticks, midStrobe pulses for one cycle (floor(L/2)+1)·D clocks after the start of that bit.
- R7: The edge that samples frameStart high sets bitIdx to 1. Bit b ends L_b·D clocks after the previous boundary, or after that start edge for bit 1. bitStrobe is high for one cycle on that edge, and in the same cycle bitIdx steps to b+1.
- R8: When bit 10 ends, bitStrobe and frameDone are both high for one cycle and bitIdx returns to 0. No further strobe appears until the next frameStart.
- R9: divisor and osampWord are captured on the edge that samples frameStart. Changes to them during a frame have no effect on that frame.
- R10: A frameStart during a running frame abandons that frame and restarts timing from bit 1, with the prescaler and tick count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divisor | input | 10 | Base-tick prescaler value D |
| osampWord | input | 32 | Four packed per-group tick counts |
| frameStart | input | 1 | One-cycle pulse that begins a frame |
| bitStrobe | output | 1 | Pulses at the end of every bit |
| midStrobe | output | 1 | Pulses at the sampling point of every bit |
| bitIdx | output | 4 | Current bit 1..10, 0 while idle |
| frameDone | output | 1 | Pulses when bit 10 ends |

## Verification
The corner cases that are hardest to reach from the ports come from configurations where the strobes collide. With a one-tick bit, the mid-bit and boundary strobes fall on the same edge. Other hard cases are a zero field inside a fractional word, ignored high bits in each byte, and inputs that change or restart in the middle of a frame. The bench reaches these by sweeping divisors 0 to 3 against a set of oversampling words that includes single-tick fields, mixed lengths, a zero field and set filler bits. It also sweeps one field over a range while holding the others fixed. For every frame it computes each boundary and sampling cycle from the cumulative bit lengths and compares them cycle by cycle. Separate runs scramble the inputs just after a start and issue a second start in the middle of a frame.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  // Commands from the control to the datapath.
  typedef struct packed {
    logic load;   // capture configuration and clear counters
    logic run;    // a frame is being timed
  } ubtCmd_t;

  // Strobes from the datapath back to the control.
  typedef struct packed {
    logic baseTick;
    logic midTick;
    logic bitDone;
  } ubtFlags_t;

  // Which oversampling field governs a frame bit (1..10).
  function automatic logic [1:0] groupOf(input logic [3:0] idx);
    if (idx <= 4'd3)      return 2'd0;
    else if (idx <= 4'd6) return 2'd1;
    else if (idx <= 4'd8) return 2'd2;
    else                  return 2'd3;
  endfunction

endpackage

// File: rtl/ubt_datapath.sv
module ubt_datapath
  import ubt_pkg::*;
#(
  parameter int DIV_W        = 10,
  parameter int FIELD_W      = 6,
  parameter int FIELD_STRIDE = 8,
  parameter int NUM_FIELDS   = 4,
  parameter int DEFAULT_OSR  = 16,
  parameter int IDX_W        = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [DIV_W-1:0]                    divisor,
  input  logic [NUM_FIELDS*FIELD_STRIDE-1:0]  osampWord,
  input  ubtCmd_t                             cmd,
  input  logic [IDX_W-1:0]                    bitIdx,
  output ubtFlags_t                           flags
);

  localparam logic [FIELD_W-1:0] DEF_LEN = FIELD_W'(DEFAULT_OSR);

  logic [FIELD_W-1:0] rawField [NUM_FIELDS];
  logic [FIELD_W-1:0] effField [NUM_FIELDS];
  logic [FIELD_W-1:0] fieldReg [NUM_FIELDS];
  logic               anyField;
  logic               fracReg;
  logic [DIV_W-1:0]   effDiv;
  logic [DIV_W-1:0]   divReg;
  logic [DIV_W-1:0]   preCnt;
  logic [FIELD_W-1:0] tickCnt;
  logic [FIELD_W-1:0] bitLen;
  logic               preWrap;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
      assign rawField[gi] = osampWord[gi*FIELD_STRIDE +: FIELD_W];
      assign effField[gi] = (rawField[gi] == '0) ? FIELD_W'(1) : rawField[gi];
    end
  endgenerate

  always_comb begin
    anyField = 1'b0;
    for (int k = 0; k < NUM_FIELDS; k++) anyField = anyField | (rawField[k] != '0);
  end

  assign effDiv = (divisor == '0) ? DIV_W'(1) : divisor;

  // Configuration is latched only when a frame starts.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg  <= DIV_W'(1);
      fracReg <= 1'b0;
      for (int k = 0; k < NUM_FIELDS; k++) fieldReg[k] <= '0;
    end else if (cmd.load) begin
      divReg  <= effDiv;
      fracReg <= anyField;
      for (int k = 0; k < NUM_FIELDS; k++) fieldReg[k] <= effField[k];
    end
  end

  always_comb begin
    if (fracReg) bitLen = fieldReg[groupOf(bitIdx)];
    else         bitLen = DEF_LEN;
  end

  assign preWrap        = (preCnt == divReg - DIV_W'(1));
  assign flags.baseTick = cmd.run && preWrap;
  assign flags.midTick  = flags.baseTick && (tickCnt == (bitLen >> 1));
  assign flags.bitDone  = flags.baseTick && (tickCnt == bitLen - FIELD_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (cmd.load) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (cmd.run) begin
      preCnt <= preWrap ? '0 : preCnt + DIV_W'(1);
      if (flags.baseTick)
        tickCnt <= flags.bitDone ? '0 : tickCnt + FIELD_W'(1);
    end
  end

endmodule

// File: rtl/ubt_control.sv
module ubt_control
  import ubt_pkg::*;
#(
  parameter int NUM_BITS = 10,
  parameter int IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  ubtFlags_t        flags,
  output ubtCmd_t          cmd,
  output logic [IDX_W-1:0] bitIdx,
  output logic             bitStrobe,
  output logic             midStrobe,
  output logic             frameDone
);

  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(NUM_BITS);

  logic running;

  assign cmd.load = frameStart;
  assign cmd.run  = running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      bitIdx    <= '0;
      bitStrobe <= 1'b0;
      midStrobe <= 1'b0;
      frameDone <= 1'b0;
    end else if (frameStart) begin
      running   <= 1'b1;
      bitIdx    <= IDX_W'(1);
      bitStrobe <= 1'b0;
      midStrobe <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      midStrobe <= running && flags.midTick;
      bitStrobe <= running && flags.bitDone;
      frameDone <= 1'b0;
      if (running && flags.bitDone) begin
        if (bitIdx == LAST_BIT) begin
          running   <= 1'b0;
          bitIdx    <= '0;
          frameDone <= 1'b1;
        end else begin
          bitIdx <= bitIdx + IDX_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/uart_bit_timer.sv
module uart_bit_timer
  import ubt_pkg::*;
#(
  parameter int DIV_W        = 10,
  parameter int FIELD_W      = 6,
  parameter int FIELD_STRIDE = 8,
  parameter int NUM_FIELDS   = 4,
  parameter int DEFAULT_OSR  = 16,
  parameter int NUM_BITS     = 10,
  localparam int IDX_W       = $clog2(NUM_BITS + 1),
  localparam int OS_W        = NUM_FIELDS * FIELD_STRIDE
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic [OS_W-1:0]  osampWord,
  input  logic             frameStart,
  output logic             bitStrobe,
  output logic             midStrobe,
  output logic [IDX_W-1:0] bitIdx,
  output logic             frameDone
);

  ubtCmd_t   cmd;
  ubtFlags_t flags;

  ubt_control #(
    .NUM_BITS (NUM_BITS),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .flags      (flags),
    .cmd        (cmd),
    .bitIdx     (bitIdx),
    .bitStrobe  (bitStrobe),
    .midStrobe  (midStrobe),
    .frameDone  (frameDone)
  );

  ubt_datapath #(
    .DIV_W        (DIV_W),
    .FIELD_W      (FIELD_W),
    .FIELD_STRIDE (FIELD_STRIDE),
    .NUM_FIELDS   (NUM_FIELDS),
    .DEFAULT_OSR  (DEFAULT_OSR),
    .IDX_W        (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .divisor   (divisor),
    .osampWord (osampWord),
    .cmd       (cmd),
    .bitIdx    (bitIdx),
    .flags     (flags)
  );

endmodule

// File: rtl/ubt_checker.sv
module ubt_checker #(
  parameter int NUM_BITS = 10,
  parameter int IDX_W    = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameStart,
  input logic             bitStrobe,
  input logic             midStrobe,
  input logic [IDX_W-1:0] bitIdx,
  input logic             frameDone
);

  // R7
  start_loads_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (bitIdx == IDX_W'(1)) && !bitStrobe && !frameDone);

  // R7
  idx_moves_with_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(frameStart) && (bitIdx != $past(bitIdx))) |-> bitStrobe);

  // R7
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= IDX_W'(NUM_BITS));

  // R8
  done_ends_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> bitStrobe && (bitIdx == '0) && ($past(bitIdx) == IDX_W'(NUM_BITS)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(bitIdx) == '0 && !$past(frameStart)) |-> !bitStrobe && !midStrobe && !frameDone);

endmodule

bind uart_bit_timer ubt_checker #(.NUM_BITS(NUM_BITS), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameStart (frameStart),
  .bitStrobe  (bitStrobe),
  .midStrobe  (midStrobe),
  .bitIdx     (bitIdx),
  .frameDone  (frameDone)
);

// File: tb/uart_bit_timer_bench.sv
`timescale 1ns/1ps
module uart_bit_timer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  divisor = '0;
  logic [31:0] osampWord = '0;
  logic        frameStart = 1'b0;
  logic        bitStrobe, midStrobe, frameDone;
  logic [3:0]  bitIdx;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  uart_bit_timer u_uart_bit_timer (
    .clk(clk), .rstN(rstN), .divisor(divisor), .osampWord(osampWord),
    .frameStart(frameStart), .bitStrobe(bitStrobe), .midStrobe(midStrobe),
    .bitIdx(bitIdx), .frameDone(frameDone)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Ticks per frame bit b (1..10) for an oversampling word (R3, R4, R5).
  function automatic int lenOf(input int b, input logic [31:0] os);
    int f[4];
    bit any = 1'b0;
    for (int k = 0; k < 4; k++) begin
      f[k] = int'(os[8*k +: 6]);
      if (f[k] != 0) any = 1'b1;
    end
    if (!any) return 16;
    for (int k = 0; k < 4; k++) if (f[k] == 0) f[k] = 1;
    if (b <= 3) return f[0];
    if (b <= 6) return f[1];
    if (b <= 8) return f[2];
    return f[3];
  endfunction

  // Start a frame and compare every cycle until it ends, then watch idle.
  task automatic runFrame(input logic [9:0] d, input logic [31:0] os, input bit scramble,
                          input string req);
    int dEff;
    int endAt[11];
    int midAt[11];
    int acc;
    dEff = (d == 0) ? 1 : int'(d);
    acc = 0;
    endAt[0] = 0;
    midAt[0] = -1;
    for (int b = 1; b <= 10; b++) begin
      midAt[b] = (acc + lenOf(b, os) / 2 + 1) * dEff;
      acc += lenOf(b, os);
      endAt[b] = acc * dEff;
    end
    @(negedge clk);
    divisor = d; osampWord = os; frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    check("R7", "bitIdx after start", int'(bitIdx), 1);
    if (scramble) begin
      divisor = d + 10'd5;
      osampWord = ~os;
    end
    for (int k = 1; k <= endAt[10] + 1; k++) begin
      int eb = 0;
      int em = 0;
      int bb = 0;
      @(negedge clk);
      for (int b = 1; b <= 10; b++) begin
        if (endAt[b] == k) begin eb = 1; bb = b; end
        if (midAt[b] == k) em = 1;
      end
      if (eb == 1 || bitStrobe) begin
        check(req, $sformatf("bitStrobe cycle %0d", k), int'(bitStrobe), eb);
        check("R7", $sformatf("bitIdx at boundary cycle %0d", k), int'(bitIdx),
              (bb == 10) ? 0 : bb + 1);
        check("R8", $sformatf("frameDone cycle %0d", k), int'(frameDone), (bb == 10) ? 1 : 0);
      end
      if (em == 1 || midStrobe)
        check("R6", $sformatf("midStrobe cycle %0d", k), int'(midStrobe), em);
    end
    // R8: idle after the frame
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (bitStrobe || midStrobe || frameDone || bitIdx != 0)
        check("R8", "idle output activity", 1, 0);
    end
    check("R8", "bitIdx idle", int'(bitIdx), 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] words[6];
    words[0] = 32'h0000_0000;   // x16 fallback
    words[1] = 32'h1010_1010;   // uniform 16
    words[2] = 32'h0101_0101;   // one tick per bit
    words[3] = 32'h3F02_0905;   // mixed lengths
    words[4] = 32'h0404_0004;   // zero field in fractional mode
    words[5] = 32'hC7C5_C3C1;   // filler bits set

    repeat (3) @(negedge clk);
    // R1
    check("R1", "bitStrobe in reset", int'(bitStrobe), 0);
    check("R1", "bitIdx in reset", int'(bitIdx), 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    check("R1", "midStrobe after reset", int'(midStrobe), 0);
    check("R1", "frameDone after reset", int'(frameDone), 0);
    check("R1", "bitIdx after reset", int'(bitIdx), 0);

    // R2 R3 R4 R5: divisor sweep against each word
    for (int d = 0; d <= 3; d++) begin
      for (int w = 0; w < 6; w++) begin
        string tag;
        if (w == 0) tag = "R3";
        else if (w == 4) tag = "R5";
        else if (d == 0) tag = "R2";
        else tag = "R4";
        runFrame(10'(d), words[w], 1'b0, tag);
      end
    end

    // R4: sweep the first field with the others held
    for (int m = 1; m <= 8; m++) runFrame(10'd1, {8'd3, 8'd2, 8'd7, 8'(m)}, 1'b0, "R4");

    // R2: a large divisor with short bits
    runFrame(10'd37, 32'h0201_0302, 1'b0, "R2");

    // R9: inputs change right after the start
    runFrame(10'd2, 32'h0306_0205, 1'b1, "R9");
    runFrame(10'd3, 32'h0000_0000, 1'b1, "R9");

    // R10: start, then restart in the middle of a frame
    @(negedge clk);
    divisor = 10'd4; osampWord = 32'h0000_0000; frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    repeat (150) @(negedge clk);
    check("R10", "bitIdx before restart", int'(bitIdx), 3);
    runFrame(10'd2, 32'h0503_0406, 1'b0, "R10");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule